// File: doc/BRIEF.md
# Two-Stage Bark/Bite Watchdog Timer

This block is a guest-facing watchdog with one counter and two thresholds. The counter moves forward by one on each cycle where the tick-enable input is high, so everything runs in the system clock domain. The tick-enable is expected to pulse at roughly 32.765 kHz, and both thresholds are written in units of those ticks. The first threshold is the bark point. When the count reaches it, the block raises an interrupt towards the guest as an early warning. If software still does not pet the watchdog, the count goes on to the second threshold, the bite point. There the block raises a reset request towards the system reset logic.

Software uses a small word-addressed register bus. Through it, software pets the counter, turns the watchdog on or off, hands it to a supervisor (which also parks it), reads the pending flags and sets both thresholds. Both flags are sticky. Only a pet, a stop or reset clears them. The counter stops at the bite value and does not wrap, so a missed pet can never re-arm the thresholds without anyone noticing. The bite threshold may be lowered while the counter is running, and the new value applies at the very next comparison.

Top module: `wdbb_top`

## Requirements
- R1: After reset, `bark_irq` and `bite_rst` are low. Control and status read 0. The bark register reads `BARK_RST` and the bite register reads `BITE_RST`.
- R2: The byte addresses are fixed: 0x04 pet, 0x08 control, 0x0C status, 0x10 bark threshold, 0x14 bite threshold. Read data is registered: `rdata` shows the addressed value on the cycle after `rd_en` and holds it until the next read. The bark and bite registers read back what was last written to them.
- R3: Writing the pet register with data bit 0 set clears the count to 0 and clears both flags on that clock edge. A pet write with data bit 0 clear changes nothing.
- R4: Control bit 0 is the enable. While the watchdog is stopped (enable clear, or control bit 2 set), the count and both flags are forced to 0 from the next edge onward.
- R5: While running, `bark_irq` rises one cycle after the count is at or above the bark threshold. It then stays high until a pet or a stop.
- R6: While running, `bite_rst` rises one cycle after the count is at or above the bite threshold. It then stays high until a pet or a stop.
- R7: The count only advances on a cycle where `tick` is high and the watchdog is running. It stops at the bite threshold. If the bite threshold is later raised, counting resumes from the saturated value.
- R8: Control bit 2 is the supervisor-off bit. While it is set the watchdog is stopped, whatever the state of bit 0. Control reads back bit 0 and bit 2, and all other bits read as 0.
- R9: Status bit 0 is the running state (enable set and supervisor-off clear). Status bit 1 is the bark flag and bit 2 is the bite flag. All other status bits are 0.
- R10: If a bite value lower than the current count is written while the watchdog runs, `bite_rst` rises on the cycle after the edge that performs the write.
- R11: Reads of any other address, misaligned ones included, return 0. Writes to any other address, and to status, change nothing.
- R12: If a pet and a tick fall in the same cycle, the pet wins and the count ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Slow timebase enable, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| bark_irq | output | 1 | Early-warning interrupt, sticky level |
| bite_rst | output | 1 | System reset request, sticky level |

## Verification
Register writes, pets and stops take effect on the edge where their strobe is sampled. A threshold crossing is one cycle later than a write: the count moves on one edge, and the flag that compares against it sets on the next edge. Read data appears one edge after `rd_en`. The bench drives every input on the falling edge. A behavioural model in the bench advances on each rising edge, and outputs are compared with it on every falling edge, half a cycle after the edge that produced them. Each directed check waits the exact number of edges worked out above. For example, after five ticks it checks that the bark is still low, and after one more idle cycle it checks that the bark is high. This pins the one-cycle flag latency and shows that the count is not off by one.

// File: rtl/wdbb_pkg.sv
package wdbb_pkg;
   // Byte offsets of the word registers on the bus
   localparam int unsigned OFS_PET    = 32'h04;
   localparam int unsigned OFS_CTRL   = 32'h08;
   localparam int unsigned OFS_STAT   = 32'h0C;
   localparam int unsigned OFS_BARK   = 32'h10;
   localparam int unsigned OFS_BITE   = 32'h14;
   // Control bit positions
   localparam int unsigned CTRL_EN    = 0;
   localparam int unsigned CTRL_SUP   = 2;
   // Threshold stages: index 0 warns, index 1 resets
   localparam int unsigned NUM_STAGES = 2;
   localparam int unsigned STG_BARK   = 0;
   localparam int unsigned STG_BITE   = 1;

   typedef struct packed {
      logic sup_off;
      logic enable;
   } wdbb_ctrl_t;
endpackage

// File: rtl/wdbb_regs.sv
module wdbb_regs
   import wdbb_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned CNT_W    = 32,
   parameter int unsigned BARK_RST = 360435,
   parameter int unsigned BITE_RST = 458710
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              bark_f,
   input  logic              bite_f,
   output logic [DATA_W-1:0] rdata,
   output logic              run,
   output logic              pet,
   output logic [CNT_W-1:0]  bark_t,
   output logic [CNT_W-1:0]  bite_t
);
   localparam logic [ADDR_W-1:0] A_PET  = ADDR_W'(OFS_PET);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
   localparam logic [ADDR_W-1:0] A_BARK = ADDR_W'(OFS_BARK);
   localparam logic [ADDR_W-1:0] A_BITE = ADDR_W'(OFS_BITE);

   wdbb_ctrl_t        ctrl_q;
   logic [DATA_W-1:0] rd_nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         bark_t <= CNT_W'(BARK_RST);
         bite_t <= CNT_W'(BITE_RST);
      end else if (wr_en) begin
         if (addr == A_CTRL) begin
            ctrl_q.enable  <= wdata[CTRL_EN];
            ctrl_q.sup_off <= wdata[CTRL_SUP];
         end
         if (addr == A_BARK) bark_t <= wdata[CNT_W-1:0];
         if (addr == A_BITE) bite_t <= wdata[CNT_W-1:0];
      end
   end

   assign run = ctrl_q.enable & ~ctrl_q.sup_off;
   assign pet = wr_en & (addr == A_PET) & wdata[0];

   always_comb begin
      rd_nxt = '0;
      case (addr)
         A_CTRL: begin
            rd_nxt[CTRL_EN]  = ctrl_q.enable;
            rd_nxt[CTRL_SUP] = ctrl_q.sup_off;
         end
         A_STAT: rd_nxt[2:0] = {bite_f, bark_f, run};
         A_BARK: rd_nxt = DATA_W'(bark_t);
         A_BITE: rd_nxt = DATA_W'(bite_t);
         default: rd_nxt = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_nxt;
   end
endmodule

// File: rtl/wdbb_counter.sv
module wdbb_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic             pet,
   input  logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] cnt
);
   logic at_limit;
   assign at_limit = (cnt >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt <= '0;
      else if (pet || !run)             cnt <= '0;
      else if (tick && !at_limit)       cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/wdbb_stage.sv
module wdbb_stage #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             pet,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] thr,
   output logic             flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               flag <= 1'b0;
      else if (pet || !run)     flag <= 1'b0;
      else if (cnt >= thr)      flag <= 1'b1;
   end
endmodule

// File: rtl/wdbb_top.sv
module wdbb_top
   import wdbb_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned CNT_W    = 32,
   parameter int unsigned BARK_RST = 360435,
   parameter int unsigned BITE_RST = 458710
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              bark_irq,
   output logic              bite_rst
);
   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("wdbb_top: CNT_W must lie in 2..DATA_W");
   end
   if (DATA_W < 3) begin : g_bad_data
      $error("wdbb_top: DATA_W too narrow for status");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("wdbb_top: ADDR_W cannot reach the bite register");
   end
   if (BITE_RST < BARK_RST) begin : g_bad_rst
      $error("wdbb_top: reset bite value below reset bark value");
   end

   logic                 run;
   logic                 pet;
   logic [CNT_W-1:0]     cnt;
   logic [CNT_W-1:0]     bark_t;
   logic [CNT_W-1:0]     bite_t;
   logic [CNT_W-1:0]     thr   [NUM_STAGES];
   logic [NUM_STAGES-1:0] flags;

   assign thr[STG_BARK] = bark_t;
   assign thr[STG_BITE] = bite_t;

   wdbb_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
      .BARK_RST(BARK_RST), .BITE_RST(BITE_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata),
      .bark_f(flags[STG_BARK]), .bite_f(flags[STG_BITE]),
      .rdata(rdata), .run(run), .pet(pet),
      .bark_t(bark_t), .bite_t(bite_t)
   );

   wdbb_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .pet(pet),
      .limit(bite_t), .cnt(cnt)
   );

   for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
      wdbb_stage #(.CNT_W(CNT_W)) u_stg (
         .clk(clk), .rst_n(rst_n), .run(run), .pet(pet),
         .cnt(cnt), .thr(thr[s]), .flag(flags[s])
      );
   end

   assign bark_irq = flags[STG_BARK];
   assign bite_rst = flags[STG_BITE];
endmodule

// File: rtl/wdbb_chk.sv
module wdbb_chk
   import wdbb_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              wr_en,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input logic              bark_irq,
   input logic              bite_rst,
   input logic              run,
   input logic [CNT_W-1:0]  cnt
);
   logic pet_w;
   logic mapped;
   assign pet_w  = wr_en && (addr == ADDR_W'(OFS_PET)) && wdata[0];
   assign mapped = (addr == ADDR_W'(OFS_CTRL)) || (addr == ADDR_W'(OFS_STAT)) ||
                   (addr == ADDR_W'(OFS_BARK)) || (addr == ADDR_W'(OFS_BITE));

   a_r3_pet_clears: assert property (@(posedge clk) disable iff (!rst_n)
      pet_w |=> (!bark_irq && !bite_rst));

   a_r4_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!bark_irq && !bite_rst && cnt == '0));

   a_r5_bark_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (bark_irq && run && !pet_w) |=> bark_irq);

   a_r6_bite_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (bite_rst && run && !pet_w) |=> bite_rst);

   a_r7_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && run && !pet_w) |=> $stable(cnt));

   a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ({1'b0, cnt} <= {1'b0, $past(cnt)} + 1'b1));

   a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !mapped) |=> (rdata == '0));
endmodule

bind wdbb_top wdbb_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
   .addr(addr), .wdata(wdata), .rdata(rdata), .bark_irq(bark_irq),
   .bite_rst(bite_rst), .run(run), .cnt(cnt)
);

// File: tb/sim_wdbb_top.sv
module sim_wdbb_top;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 8;
   localparam int DATA_W     = 32;
   localparam int BARK_RST   = 360435;
   localparam int BITE_RST   = 458710;
   localparam int WATCHDOG   = 20000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              tick = 1'b0;
   logic              wr_en = 1'b0;
   logic              rd_en = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [DATA_W-1:0] wdata = '0;
   logic [DATA_W-1:0] rdata;
   logic              bark_irq;
   logic              bite_rst;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 1'b0;

   // behavioural reference state
   bit          m_en, m_sup, m_bark, m_bite;
   longint      m_cnt, m_bark_t, m_bite_t;
   logic [31:0] m_rd;

   wdbb_top u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata),
      .bark_irq(bark_irq), .bite_rst(bite_rst)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%0h exp=%0h t=%0t", tag, got, exp, $time);
      end
   endtask

   // reference model: advances on each rising edge from the spec rules
   always @(posedge clk) begin
      if (!rst_n) begin
         m_en = 0; m_sup = 0; m_bark = 0; m_bite = 0; m_cnt = 0;
         m_bark_t = BARK_RST; m_bite_t = BITE_RST; m_rd = 0;
      end else begin
         bit     running, petting, nb, nt;
         longint nc;
         running = m_en && !m_sup;
         petting = wr_en && addr == 8'h04 && wdata[0];
         nb = m_bark; nt = m_bite; nc = m_cnt;
         if (!running || petting) begin
            nb = 0; nt = 0; nc = 0;
         end else begin
            if (m_cnt >= m_bark_t) nb = 1;
            if (m_cnt >= m_bite_t) nt = 1;
            if (tick && m_cnt < m_bite_t) nc = m_cnt + 1;
         end
         if (rd_en) begin
            case (addr)
               8'h08: m_rd = {29'd0, m_sup, 1'b0, m_en};
               8'h0C: m_rd = {29'd0, m_bite, m_bark, running};
               8'h10: m_rd = m_bark_t[31:0];
               8'h14: m_rd = m_bite_t[31:0];
               default: m_rd = 0;
            endcase
         end
         if (wr_en) begin
            if (addr == 8'h08) begin m_en = wdata[0]; m_sup = wdata[2]; end
            if (addr == 8'h10) m_bark_t = wdata;
            if (addr == 8'h14) m_bite_t = wdata;
         end
         m_bark = nb; m_bite = nt; m_cnt = nc;
      end
   end

   // per-cycle comparison, half a cycle after the rising edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R5 bark vs model", {31'd0, bark_irq}, {31'd0, m_bark});
         chk("R6 bite vs model", {31'd0, bite_rst}, {31'd0, m_bite});
         chk("R2 rdata vs model", rdata, m_rd);
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG && !done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog expired after %0d cycles", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic run_cyc(input int n, input bit tk);
      tick = tk;
      repeat (n) @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; addr = '0; wdata = '0;
   endtask

   task automatic rdchk(input logic [7:0] a, input logic [31:0] exp, input string tag);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0; addr = '0;
      chk(tag, rdata, exp);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 bark low", {31'd0, bark_irq}, 0);
      chk("R1 bite low", {31'd0, bite_rst}, 0);
      rdchk(8'h08, 0, "R1 ctrl reset");
      rdchk(8'h0C, 0, "R1 status reset");
      rdchk(8'h10, BARK_RST, "R1 bark reset value");
      rdchk(8'h14, BITE_RST, "R1 bite reset value");

      // R2 threshold programming and read back
      wr(8'h10, 5);
      wr(8'h14, 9);
      rdchk(8'h10, 5, "R2 bark readback");
      rdchk(8'h14, 9, "R2 bite readback");
      wr(8'h08, 1);
      run_cyc(10, 0);
      chk("R7 no tick no count", {31'd0, bark_irq}, 0);
      run_cyc(5, 1);
      chk("R5 bark not yet at count 5", {31'd0, bark_irq}, 0);
      run_cyc(1, 0);
      chk("R5 bark one cycle after reach", {31'd0, bark_irq}, 1);
      rdchk(8'h0C, 3, "R9 status run+bark");

      // R3 pet with bit0 clear ignored, then real pet
      wr(8'h04, 0);
      chk("R3 pet data0 clear ignored", {31'd0, bark_irq}, 1);
      wr(8'h04, 1);
      chk("R3 pet clears bark", {31'd0, bark_irq}, 0);
      run_cyc(9, 1);
      chk("R6 bite not yet", {31'd0, bite_rst}, 0);
      run_cyc(1, 0);
      chk("R6 bite asserted", {31'd0, bite_rst}, 1);
      rdchk(8'h0C, 7, "R9 status all set");

      // R7 saturation at bite, then raise bite
      wr(8'h10, 12);
      wr(8'h04, 1);
      run_cyc(20, 1);
      chk("R7 saturated below bark", {31'd0, bark_irq}, 0);
      chk("R6 bite at saturation", {31'd0, bite_rst}, 1);
      wr(8'h14, 20);
      run_cyc(2, 1);
      run_cyc(1, 0);
      chk("R7 resume count 11", {31'd0, bark_irq}, 0);
      run_cyc(1, 1);
      run_cyc(1, 0);
      chk("R7 resume reaches bark", {31'd0, bark_irq}, 1);

      // R10 shorter bite takes effect at once
      wr(8'h10, 15);
      wr(8'h04, 1);
      run_cyc(8, 1);
      chk("R10 bite low at count 8", {31'd0, bite_rst}, 0);
      wr(8'h14, 4);
      chk("R10 bite low on write edge", {31'd0, bite_rst}, 0);
      run_cyc(1, 0);
      chk("R10 bite after shorter value", {31'd0, bite_rst}, 1);

      // R12 pet beats tick
      wr(8'h10, 1);
      wr(8'h14, 50);
      tick = 1'b1;
      wr(8'h04, 1);
      tick = 1'b0;
      run_cyc(1, 0);
      chk("R12 pet wins over tick", {31'd0, bark_irq}, 0);
      run_cyc(1, 1);
      run_cyc(1, 0);
      chk("R5 bark at threshold 1", {31'd0, bark_irq}, 1);

      // R8 supervisor-off
      wr(8'h08, 5);
      run_cyc(1, 0);
      chk("R8 sup clears bark", {31'd0, bark_irq}, 0);
      run_cyc(10, 1);
      chk("R8 sup no bark", {31'd0, bark_irq}, 0);
      rdchk(8'h08, 5, "R8 ctrl readback");
      rdchk(8'h0C, 0, "R9 status not running");

      // R4 enable off
      wr(8'h08, 1);
      run_cyc(3, 1);
      run_cyc(1, 0);
      chk("R4 enabled bark", {31'd0, bark_irq}, 1);
      wr(8'h08, 0);
      run_cyc(1, 0);
      chk("R4 disable clears bark", {31'd0, bark_irq}, 0);
      run_cyc(60, 1);
      chk("R4 disabled no bite", {31'd0, bite_rst}, 0);
      rdchk(8'h08, 0, "R4 ctrl off");

      // R11 unmapped access
      rdchk(8'h00, 0, "R11 read 0x00");
      rdchk(8'h18, 0, "R11 read 0x18");
      rdchk(8'h11, 0, "R11 read misaligned");
      rdchk(8'h04, 0, "R11 pet reads zero");
      wr(8'h18, 32'hFFFF_FFFF);
      wr(8'h00, 32'hFFFF_FFFF);
      wr(8'h11, 32'hFFFF_FFFF);
      wr(8'h0C, 32'hFFFF_FFFF);
      rdchk(8'h10, 1, "R11 bark untouched");
      rdchk(8'h14, 50, "R11 bite untouched");
      rdchk(8'h08, 0, "R11 ctrl untouched");
      chk("R11 outputs quiet", {30'd0, bite_rst, bark_irq}, 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule